// File: doc/BRIEF.md
# Priority-Pool Bus Slave Arbiter

This block decides which of several bus masters may use one shared slave. Every master is placed in one of four priority pools by a 2-bit configuration field. Pool 3 is for latency-critical traffic, pool 2 for latency-sensitive traffic, pool 1 for bandwidth-sensitive traffic and pool 0 for background traffic. A request from a higher pool always beats any request from a lower pool. Inside pools 3 and 0 the masters take turns in round-robin order, and each of these two pools keeps its own last-winner pointer. Inside pools 2 and 1 the lowest master index wins.

Ownership changes only at an access boundary. A boundary is a completed transfer (`xfer_done`) that is either the last beat of a burst or that arrives after the slot-cycle budget has run out. The budget is a down-counter. It is reloaded from `slot_limit` at every grant and counts down once per clock while a master owns the slave. A limit of 0 turns the budget off, so a burst keeps the slave until its last beat. The block drives the boundary it uses on `access_end`. When nobody is requesting at a boundary, the grant stays parked on the last owner and the counter freezes.

The controller has three states. IDLE is the state after reset, with no grant. OWN means a master holds the slave. PARK means the grant is held while no master is requesting. The transitions are:
- START: IDLE to OWN, on any request.
- REGRANT: OWN to OWN, at a boundary while requests are present.
- PARK_IN: OWN to PARK, at a boundary with no request.
- WAKE: PARK to OWN, on any request.

Top module: `pool_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros and `access_end` is 0. The controller stays in IDLE until a request arrives.
- R2: At every arbitration, the winner comes from the highest pool that has a request. The pool of master i is `pool_cfg[2i+1:2i]`, and a larger value means a higher pool.
- R3: In pools 2 and 1, the requesting master with the lowest index wins, regardless of earlier grants.
- R4: In pool 3, the search starts at the index just after the last pool-3 winner and wraps around. The pointer resets to N-1, so the first search starts at master 0. A waiting pool-3 master is therefore served before any other pool-3 master is served twice.
- R5: Pool 0 uses the same round-robin rule with its own separate pointer. All pools reset to 0, so the default behaviour is plain round-robin across all masters.
- R6: While in OWN, `grant` changes only on the clock edge that follows a cycle in which `access_end` is 1.
- R7: In OWN, `access_end` is 1 exactly when `xfer_done` is 1 and either `burst_last` is 1 or the budget is spent. With a limit L > 0 captured at the grant, the budget is spent from the L-th clock edge after the grant edge onward.
- R8: If `slot_limit` was 0 when the grant was made, `access_end` is 1 only when `xfer_done` and `burst_last` are both 1.
- R9: A boundary with no request moves the controller to PARK and keeps the previous grant. In PARK, `access_end` stays 0. A request arriving in PARK is granted on the next clock edge.
- R10: `grant` is one-hot or all zeros at all times. Bit i of `grant` selects master i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MASTERS | Request vector, one bit per master |
| pool_cfg | input | 2*N_MASTERS | Pool field for each master, bits [2i+1:2i] belong to master i |
| slot_limit | input | SLOT_W | Slot-cycle budget; 0 disables it |
| xfer_done | input | 1 | A bus transfer completes in this cycle |
| burst_last | input | 1 | The completing transfer is the last beat of its burst |
| grant | output | N_MASTERS | One-hot grant vector |
| access_end | output | 1 | Boundary used for re-arbitration in this cycle |

## Verification
The bench builds the arbiter with N_MASTERS = 4 and SLOT_W = 4. Four masters are enough to wrap both round-robin pointers and to place masters in all four pools at the same time. A 4-bit budget lets a run reach the exact cycle at which a limit of 3 expires, and lets it hold a disabled limit over a twenty-cycle burst, in only a few clocks.

// File: rtl/pool_arb_pkg.sv
package pool_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OWN  = 2'd1,
        ST_PARK = 2'd2
    } arb_state_e;

    typedef logic [1:0] pool_t;

    localparam int     NUM_POOLS = 4;
    localparam pool_t  POOL_BACKGROUND = 2'd0;
    localparam pool_t  POOL_CRITICAL   = 2'd3;
endpackage

// File: rtl/pool_arb_rr_pick.sv
// Rotating search: first set bit strictly after 'last', wrapping around.
module pool_arb_rr_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int unsigned j;
            j = (int'(last) + k) % N;
            if (!found && cand[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/pool_arb_select.sv
// Combinational winner selection over the four pools.
module pool_arb_select import pool_arb_pkg::*; #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]   req,
    input  logic [2*N-1:0] pool_cfg,
    input  logic [IW-1:0]  ptr_crit,
    input  logic [IW-1:0]  ptr_bg,
    output logic           any,
    output logic [IW-1:0]  win_idx,
    output pool_t          win_pool
);
    logic [N-1:0]  pmask [NUM_POOLS];
    logic          pfound[NUM_POOLS];
    logic [IW-1:0] pidx  [NUM_POOLS];

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        always_comb begin
            for (int i = 0; i < N; i++)
                pmask[p][i] = req[i] && (pool_cfg[2*i +: 2] == pool_t'(p));
        end

        if (p == int'(POOL_CRITICAL) || p == int'(POOL_BACKGROUND)) begin : g_rr
            pool_arb_rr_pick #(.N(N), .IW(IW)) u_rr (
                .cand  (pmask[p]),
                .last  ((p == int'(POOL_CRITICAL)) ? ptr_crit : ptr_bg),
                .found (pfound[p]),
                .idx   (pidx[p])
            );
        end else begin : g_fixed
            always_comb begin
                pfound[p] = |pmask[p];
                pidx[p]   = '0;
                for (int i = N - 1; i >= 0; i--)
                    if (pmask[p][i]) pidx[p] = IW'(i);
            end
        end
    end

    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_pool = POOL_BACKGROUND;
        for (int p = 0; p < NUM_POOLS; p++) begin
            if (pfound[p]) begin
                any      = 1'b1;
                win_idx  = pidx[p];
                win_pool = pool_t'(p);
            end
        end
    end
endmodule

// File: rtl/pool_arb_slot_ctr.sv
// Slot-cycle budget: reload on grant, count down while owning.
module pool_arb_slot_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;
    logic         en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (load) begin
            cnt_q <= limit;
            en_q  <= |limit;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = en_q && (cnt_q == '0);
endmodule

// File: rtl/pool_arbiter.sv
module pool_arbiter import pool_arb_pkg::*; #(
    parameter int N_MASTERS = 8,
    parameter int SLOT_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_MASTERS-1:0]   req,
    input  logic [2*N_MASTERS-1:0] pool_cfg,
    input  logic [SLOT_W-1:0]      slot_limit,
    input  logic                   xfer_done,
    input  logic                   burst_last,
    output logic [N_MASTERS-1:0]   grant,
    output logic                   access_end
);
    localparam int IW = $clog2(N_MASTERS);
    localparam logic [IW-1:0] PTR_RESET = IW'(N_MASTERS - 1);

    arb_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, ptr_crit_q, ptr_bg_q;
    logic          any, take, owning, slot_spent;
    logic [IW-1:0] win_idx;
    pool_t         win_pool;

    pool_arb_select #(.N(N_MASTERS), .IW(IW)) u_sel (
        .req      (req),
        .pool_cfg (pool_cfg),
        .ptr_crit (ptr_crit_q),
        .ptr_bg   (ptr_bg_q),
        .any      (any),
        .win_idx  (win_idx),
        .win_pool (win_pool)
    );

    pool_arb_slot_ctr #(.W(SLOT_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .run     (owning),
        .limit   (slot_limit),
        .expired (slot_spent)
    );

    assign owning     = (state_q == ST_OWN);
    assign access_end = owning && xfer_done && (burst_last || slot_spent);
    assign take       = any && (!owning || access_end);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any)        state_d = ST_OWN;                  // START
            ST_OWN:  if (access_end) state_d = any ? ST_OWN : ST_PARK;  // REGRANT / PARK_IN
            ST_PARK: if (any)        state_d = ST_OWN;                  // WAKE
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Owner and round-robin pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q    <= '0;
            ptr_crit_q <= PTR_RESET;
            ptr_bg_q   <= PTR_RESET;
        end else if (take) begin
            owner_q <= win_idx;
            if (win_pool == POOL_CRITICAL)   ptr_crit_q <= win_idx;
            if (win_pool == POOL_BACKGROUND) ptr_bg_q   <= win_idx;
        end
    end

    // Outputs
    always_comb begin
        grant = '0;
        if (state_q != ST_IDLE) grant[owner_q] = 1'b1;
    end
endmodule

// File: rtl/pool_arbiter_sva.sv
module pool_arbiter_sva #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   req,
    input logic [2*N-1:0] pool_cfg,
    input logic [N-1:0]   grant,
    input logic           xfer_done,
    input logic           burst_last,
    input logic           access_end,
    input logic           in_own
);
    logic [1:0] top_req_pool, grant_pool;

    always_comb begin
        top_req_pool = 2'd0;
        grant_pool   = 2'd0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && pool_cfg[2*i +: 2] > top_req_pool) top_req_pool = pool_cfg[2*i +: 2];
            if (grant[i]) grant_pool = pool_cfg[2*i +: 2];
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));                                                        // R10

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_own && !access_end) |=> $stable(grant));                             // R6

    AST_END_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        access_end |-> (xfer_done && in_own));                                   // R7

    AST_PARK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_own && access_end && !(|req)) |=> ($stable(grant) && !access_end));  // R9

    AST_TOP_POOL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_own && access_end && (|req)) |=>
            (!$stable(pool_cfg) || grant_pool == $past(top_req_pool)));          // R2

    AST_LAST_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_own && xfer_done && burst_last) |-> access_end);                     // R8
endmodule

bind pool_arbiter pool_arbiter_sva #(.N(N_MASTERS)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .pool_cfg   (pool_cfg),
    .grant      (grant),
    .xfer_done  (xfer_done),
    .burst_last (burst_last),
    .access_end (access_end),
    .in_own     (owning)
);

// File: tb/pool_arbiter_test.sv
`timescale 1ns/1ps
module pool_arbiter_test;
    localparam int N  = 4;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [2*N-1:0] pool_cfg = '0;
    logic [SW-1:0] slot_limit = '0;
    logic          xfer_done = 1'b0;
    logic          burst_last = 1'b0;
    logic [N-1:0]  grant;
    logic          access_end;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pool_arbiter #(.N_MASTERS(N), .SLOT_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .pool_cfg(pool_cfg),
        .slot_limit(slot_limit), .xfer_done(xfer_done), .burst_last(burst_last),
        .grant(grant), .access_end(access_end)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Completes one last beat; the new grant is visible afterwards.
    task automatic end_burst();
        xfer_done = 1'b1; burst_last = 1'b1;
        #1 chk("R7 boundary on last beat", access_end, 1);
        @(negedge clk);
        xfer_done = 1'b0; burst_last = 1'b0;
        #1;
    endtask

    function automatic logic [2*N-1:0] pools(input int p0, p1, p2, p3);
        return {2'(p3), 2'(p2), 2'(p1), 2'(p0)};
    endfunction

    task automatic t_reset();
        tick();
        chk("R1 grant after reset", grant, 0);
        chk("R1 access_end after reset", access_end, 0);
        req = 4'b0000; xfer_done = 1'b1; burst_last = 1'b1;
        tick();
        chk("R1 idle without request", grant, 0);
        xfer_done = 1'b0; burst_last = 1'b0;
    endtask

    task automatic t_default_rr();
        req = 4'b1111;
        tick();
        chk("R5 first grant master 0", grant, 4'b0001);
        end_burst(); chk("R5 rr to master 1", grant, 4'b0010);
        end_burst(); chk("R5 rr to master 2", grant, 4'b0100);
        end_burst(); chk("R5 rr to master 3", grant, 4'b1000);
        end_burst(); chk("R5 rr wraps to master 0", grant, 4'b0001);
    endtask

    task automatic t_pools();
        pool_cfg = pools(0, 2, 2, 1);
        end_burst(); chk("R3 pool 2 lowest index", grant, 4'b0010);
        end_burst(); chk("R3 fixed priority repeats", grant, 4'b0010);
        req = 4'b1001;
        end_burst(); chk("R2 pool 1 beats pool 0", grant, 4'b1000);
    endtask

    task automatic t_crit_rr();
        pool_cfg = pools(3, 1, 3, 1);
        req = 4'b1111;
        end_burst(); chk("R4 pool 3 starts at master 0", grant, 4'b0001);
        end_burst(); chk("R4 pool 3 rotates to master 2", grant, 4'b0100);
        end_burst(); chk("R4 pool 3 wraps to master 0", grant, 4'b0001);
    endtask

    task automatic t_slot_limit();
        pool_cfg = pools(0, 0, 0, 0);
        slot_limit = 4'd3;
        end_burst(); chk("R5 pool 0 pointer kept", grant, 4'b0010);
        tick(); tick();
        xfer_done = 1'b1; burst_last = 1'b0;
        #1 chk("R7 budget not yet spent", access_end, 0);
        tick();
        chk("R7 budget spent at third edge", access_end, 1);
        chk("R6 grant held before boundary", grant, 4'b0010);
        tick();
        chk("R7 mid-burst regrant", grant, 4'b0100);
        xfer_done = 1'b0;
    endtask

    task automatic t_no_limit();
        int ends = 0;
        slot_limit = 4'd0;
        end_burst(); chk("R5 grant master 3", grant, 4'b1000);
        xfer_done = 1'b1; burst_last = 1'b0;
        for (int c = 0; c < 20; c++) begin
            #1 if (access_end) ends++;
            tick();
        end
        chk("R8 no boundary without last beat", ends, 0);
        chk("R8 owner kept over long burst", grant, 4'b1000);
        xfer_done = 1'b0;
        end_burst(); chk("R8 last beat hands over", grant, 4'b0001);
    endtask

    task automatic t_park();
        req = 4'b0000;
        end_burst(); chk("R9 parked on last owner", grant, 4'b0001);
        xfer_done = 1'b1; burst_last = 1'b1;
        #1 chk("R9 no boundary while parked", access_end, 0);
        tick();
        chk("R9 still parked", grant, 4'b0001);
        xfer_done = 1'b0; burst_last = 1'b0;
        req = 4'b0100;
        tick();
        chk("R9 wake grant next edge", grant, 4'b0100);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_rr();
        t_pools();
        t_crit_rr();
        t_slot_limit();
        t_no_limit();
        t_park();
        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule